// File: doc/BRIEF.md
# Nibble-Bus Flash Read Target

This block is the target side of a read on a 4-bit multiplexed firmware-hub style bus. A frame strobe (active low) brackets each cycle. The host first sends a start code. It then sends a device-select nibble, which the block compares with its strap pins. Next come a 28-bit address, most significant nibble first, and a size nibble that asks for a power-of-two burst. After the host's turnaround clock the block takes the bus, drives two wait codes and a ready code, and then streams the bytes, low nibble first. A final turnaround nibble hands the bus back to the host.

Bytes come from a synchronous byte-wide read port: a request in one clock returns data in the next. The block keeps one fetch ahead of the bus, so the data nibbles follow each other with no gaps. A frame strobe that drops in the middle of a cycle cancels the cycle and releases the bus in that same clock. If the strobe drops together with a start code, a new cycle begins.

Top module: `nbt_read_target`

## Requirements
- R1: After reset the bus drivers are off (`lad_oe` = 0) and no memory read is requested. A cycle begins only at a rising edge where `frame_n` = 0 and `lad_in` = 4'b1101.
- R2: The nibble after the start code is compared with `strap_id`. On a mismatch the block does not drive the bus for the rest of that cycle and waits for the next start code.
- R3: The address is taken over the next ADDR_NIBS (default 7) clocks, most significant nibble first, giving a 28-bit byte address.
- R4: The size nibble selects the burst length: 4'b0000, 4'b0001, 4'b0010, 4'b0100 and 4'b0111 give 1, 2, 4, 16 and 128 bytes.
- R5: Any other size nibble gives a single-byte transfer.
- R6: For a burst of 2^n bytes the low n address bits are cleared, and the burst reads ascending addresses from that aligned base.
- R7: The host owns one turnaround clock after the size nibble. In the clock after that, the block drives 4'b1111 with `lad_oe` = 1.
- R8: After its turnaround nibble the block drives 4'b0101 for exactly two clocks, then 4'b0000 for one clock.
- R9: Each byte then takes two clocks, bits [3:0] first and bits [7:4] second, with no idle clocks between bytes.
- R10: After the last data nibble the block drives 4'b1111 for one clock and then turns its drivers off.
- R11: If `frame_n` goes low while a cycle is under way, `lad_oe` drops in that same clock and the cycle is abandoned. If the same clock carries a start code, a new cycle begins.
- R12: `lad_oe` comes from a register. It is high only from the block's turnaround clock through its closing 4'b1111 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Cycle frame strobe, active low |
| lad_in | input | 4 | Nibble bus as seen at the pins |
| strap_id | input | 4 | Device-select strap value |
| lad_out | output | 4 | Nibble the block drives |
| lad_oe | output | 1 | Enable for the nibble bus drivers |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 4*ADDR_NIBS | Byte address of the request |
| mem_rd_data | input | 8 | Read data, valid the clock after a request |

## Verification
The bench builds the block with its default parameters: seven address nibbles, a largest burst of 2^7 bytes, and a driven turnaround nibble. With these values a single run reaches every legal size code, including the full 128-byte burst. The masking of all seven low address bits can be seen from an unaligned start address. Because the turnaround nibble is driven, the enable window can be checked nibble by nibble from the first target clock to the last. The backing memory holds a pattern computed from the address, so any error in the aligned base, the byte order or the nibble order changes the data the bench sees.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ID,
      S_ADDR,
      S_SIZE,
      S_HTAR,
      S_TTAR,
      S_WSYNC,
      S_RSYNC,
      S_DLO,
      S_DHI,
      S_ETAR
   } nbt_state_e;

   localparam logic [3:0] NIB_START = 4'b1101;
   localparam logic [3:0] NIB_TAR   = 4'b1111;
   localparam logic [3:0] NIB_WAIT  = 4'b0101;
   localparam logic [3:0] NIB_READY = 4'b0000;

endpackage

// File: rtl/nbt_size_map.sv
module nbt_size_map #(
   parameter int MAX_LOG = 7,
   localparam int LW     = (MAX_LOG < 2) ? 1 : $clog2(MAX_LOG + 1)
) (
   input  logic [3:0]    code,
   output logic [LW-1:0] size_log
);

   logic legal;

   generate
      if (MAX_LOG >= 7) begin : g_full
         always_comb legal = (code == 4'd0) || (code == 4'd1) || (code == 4'd2)
                             || (code == 4'd4) || (code == 4'd7);
      end else begin : g_capped
         always_comb legal = ((code == 4'd0) || (code == 4'd1) || (code == 4'd2)
                              || (code == 4'd4) || (code == 4'd7))
                             && (int'(code) <= MAX_LOG);
      end
   endgenerate

   always_comb size_log = legal ? LW'(code) : '0;

endmodule

// File: rtl/nbt_lad_drive.sv
module nbt_lad_drive #(
   parameter bit DRIVE_TAR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       nxt_oe,
   input  logic       nxt_tar,
   input  logic [3:0] nxt_lad,
   output logic [3:0] lad_out,
   output logic       lad_oe,
   output logic       oe_q
);

   logic       oe_d;
   logic [3:0] lad_q;

   generate
      if (DRIVE_TAR) begin : g_drive_tar
         always_comb oe_d = nxt_oe;
      end else begin : g_float_tar
         always_comb oe_d = nxt_oe & ~nxt_tar;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         lad_q <= 4'b1111;
      end else begin
         oe_q  <= oe_d;
         lad_q <= nxt_lad;
      end
   end

   always_comb lad_out = lad_q;
   always_comb lad_oe  = oe_q & frame_n;

endmodule

// File: rtl/nbt_read_target.sv
module nbt_read_target
   import nbt_pkg::*;
#(
   parameter int ADDR_NIBS = 7,
   parameter int MAX_LOG   = 7,
   parameter bit DRIVE_TAR = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_n,
   input  logic [3:0]             lad_in,
   input  logic [3:0]             strap_id,
   output logic [3:0]             lad_out,
   output logic                   lad_oe,
   output logic                   mem_rd_en,
   output logic [4*ADDR_NIBS-1:0] mem_addr,
   input  logic [7:0]             mem_rd_data
);

   localparam int AW  = 4 * ADDR_NIBS;
   localparam int CW  = MAX_LOG;
   localparam int NCW = $clog2(ADDR_NIBS);
   localparam int LW  = (MAX_LOG < 2) ? 1 : $clog2(MAX_LOG + 1);

   generate
      if (ADDR_NIBS < 2 || ADDR_NIBS > 8) begin : g_bad_nibs
         $error("nbt_read_target: ADDR_NIBS must lie in 2..8");
      end
      if (MAX_LOG < 1 || MAX_LOG > 7) begin : g_bad_log
         $error("nbt_read_target: MAX_LOG must lie in 1..7");
      end
      if (CW > AW) begin : g_bad_cw
         $error("nbt_read_target: burst index wider than address");
      end
   endgenerate

   nbt_state_e      state_q, state_d;
   logic [NCW-1:0]  nib_q;
   logic [AW-1:0]   addr_q;
   logic [LW-1:0]   size_log, log_q;
   logic [CW-1:0]   idx_q, last_idx, mask_d, fetch_idx;
   logic [7:0]      byte_q;
   logic            nxt_oe, nxt_tar, oe_q;
   logic [3:0]      nxt_lad;

   nbt_size_map #(.MAX_LOG(MAX_LOG)) size_map_i (
      .code     (lad_in),
      .size_log (size_log)
   );

   always_comb mask_d   = ~({CW{1'b1}} << size_log);
   always_comb last_idx = ~({CW{1'b1}} << log_q);

   // next-state decode
   always_comb begin
      state_d = state_q;
      if (!frame_n) begin
         state_d = (lad_in == NIB_START) ? S_ID : S_IDLE;
      end else begin
         unique case (state_q)
            S_IDLE:  state_d = S_IDLE;
            S_ID:    state_d = (lad_in == strap_id) ? S_ADDR : S_IDLE;
            S_ADDR:  state_d = (nib_q == NCW'(ADDR_NIBS - 1)) ? S_SIZE : S_ADDR;
            S_SIZE:  state_d = S_HTAR;
            S_HTAR:  state_d = S_TTAR;
            S_TTAR:  state_d = S_WSYNC;
            S_WSYNC: state_d = (nib_q == NCW'(1)) ? S_RSYNC : S_WSYNC;
            S_RSYNC: state_d = S_DLO;
            S_DLO:   state_d = S_DHI;
            S_DHI:   state_d = (idx_q == last_idx) ? S_ETAR : S_DLO;
            S_ETAR:  state_d = S_IDLE;
            default: state_d = S_IDLE;
         endcase
      end
   end

   // outputs for the next clock, registered in the driver
   always_comb begin
      nxt_oe  = 1'b0;
      nxt_tar = 1'b0;
      nxt_lad = NIB_TAR;
      unique case (state_d)
         S_TTAR:  begin nxt_oe = 1'b1; nxt_tar = 1'b1; nxt_lad = NIB_TAR;   end
         S_WSYNC: begin nxt_oe = 1'b1; nxt_lad = NIB_WAIT;                  end
         S_RSYNC: begin nxt_oe = 1'b1; nxt_lad = NIB_READY;                 end
         S_DLO:   begin nxt_oe = 1'b1; nxt_lad = mem_rd_data[3:0];          end
         S_DHI:   begin nxt_oe = 1'b1; nxt_lad = byte_q[7:4];               end
         S_ETAR:  begin nxt_oe = 1'b1; nxt_lad = NIB_TAR;                   end
         default: begin nxt_oe = 1'b0; nxt_lad = NIB_TAR;                   end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         nib_q   <= '0;
         addr_q  <= '0;
         log_q   <= '0;
         idx_q   <= '0;
         byte_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_d != state_q) begin
            nib_q <= '0;
         end else if (state_q == S_ADDR || state_q == S_WSYNC) begin
            nib_q <= nib_q + NCW'(1);
         end
         if (frame_n && state_q == S_ADDR) begin
            addr_q <= {addr_q[AW-5:0], lad_in};
         end
         if (frame_n && state_q == S_SIZE) begin
            addr_q <= addr_q & ~{{(AW-CW){1'b0}}, mask_d};
            log_q  <= size_log;
         end
         if (state_q == S_RSYNC) begin
            idx_q <= '0;
         end else if (state_q == S_DHI && state_d == S_DLO) begin
            idx_q <= idx_q + CW'(1);
         end
         if (state_d == S_DLO) begin
            byte_q <= mem_rd_data;
         end
      end
   end

   // one fetch ahead: first byte requested in the second wait clock
   always_comb fetch_idx = (state_q == S_DLO) ? (idx_q + CW'(1)) : '0;
   always_comb mem_rd_en = frame_n &&
                           ((state_q == S_WSYNC && nib_q == NCW'(1)) ||
                            (state_q == S_DLO && idx_q != last_idx));
   always_comb mem_addr  = addr_q | {{(AW-CW){1'b0}}, fetch_idx};

   nbt_lad_drive #(.DRIVE_TAR(DRIVE_TAR)) drive_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .nxt_oe  (nxt_oe),
      .nxt_tar (nxt_tar),
      .nxt_lad (nxt_lad),
      .lad_out (lad_out),
      .lad_oe  (lad_oe),
      .oe_q    (oe_q)
   );

   // R3
   addr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_ADDR) |-> (int'(nib_q) < ADDR_NIBS));

   // R8
   rsync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RSYNC) |-> ($past(state_q) == S_WSYNC));

   // R9
   dhi_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DHI) |-> ($past(state_q) == S_DLO));

   // R10
   end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_ETAR && frame_n) |=> !oe_q);

   // R11
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n) |=> (!oe_q && (state_q == S_ID || state_q == S_IDLE)));

   // R12
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (state_q inside {S_TTAR, S_WSYNC, S_RSYNC, S_DLO, S_DHI, S_ETAR}));

endmodule

// File: tb/nbt_read_target_tb_top.sv
module nbt_read_target_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  strap_id = 4'h3;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic        mem_rd_en;
   logic [27:0] mem_addr;
   logic [7:0]  mem_rd_data = 8'h00;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   nbt_read_target dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_n     (frame_n),
      .lad_in      (lad_in),
      .strap_id    (strap_id),
      .lad_out     (lad_out),
      .lad_oe      (lad_oe),
      .mem_rd_en   (mem_rd_en),
      .mem_addr    (mem_addr),
      .mem_rd_data (mem_rd_data)
   );

   function automatic logic [7:0] pat(input logic [27:0] a);
      return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hC3;
   endfunction

   always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_addr);

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic put(input logic f, input logic [3:0] v);
      @(negedge clk);
      frame_n = f;
      lad_in  = v;
   endtask

   task automatic send_header(input logic [3:0] id, input logic [27:0] a,
                              input logic [3:0] sz);
      put(1'b0, 4'b1101);
      put(1'b1, id);
      for (int i = 6; i >= 0; i--) put(1'b1, a[4*i +: 4]);
      put(1'b1, sz);
      put(1'b1, 4'b1111);
   endtask

   // full read with nibble-by-nibble check of the target phase
   task automatic read_chk(input logic [27:0] a, input logic [3:0] sz,
                           input int nb, input logic [27:0] base, input string rq);
      int bad = 0;
      send_header(strap_id, a, sz);
      @(negedge clk);
      chk(lad_oe && lad_out == 4'hF, "R7", "target turnaround", {lad_oe, lad_out}, 5'h1F);
      for (int w = 0; w < 2; w++) begin
         @(negedge clk);
         chk(lad_oe && lad_out == 4'b0101, "R8", "wait code", {lad_oe, lad_out}, 5'h15);
      end
      @(negedge clk);
      chk(lad_oe && lad_out == 4'b0000, "R8", "ready code", {lad_oe, lad_out}, 5'h10);
      for (int b = 0; b < nb; b++) begin
         logic [7:0] e;
         e = pat(base + 28'(b));
         @(negedge clk);
         if (!(lad_oe && lad_out == e[3:0])) begin
            bad++;
            $display("FAIL %s R9 byte %0d low actual=%0h expected=%0h", rq, b, lad_out, e[3:0]);
         end
         @(negedge clk);
         if (!(lad_oe && lad_out == e[7:4])) begin
            bad++;
            $display("FAIL %s R9 byte %0d high actual=%0h expected=%0h", rq, b, lad_out, e[7:4]);
         end
      end
      checks++;
      if (bad != 0) failures++;
      @(negedge clk);
      chk(lad_oe && lad_out == 4'hF, "R10", "closing turnaround", {lad_oe, lad_out}, 5'h1F);
      @(negedge clk);
      chk(!lad_oe, rq, "bus released after cycle (R10 R12)", lad_oe, 0);
   endtask

   task automatic t_reset;
      chk(!lad_oe && !mem_rd_en, "R1", "reset state", {lad_oe, mem_rd_en}, 0);
   endtask

   task automatic t_no_start;
      // frame low with a non-start nibble must not begin a cycle
      put(1'b0, 4'b0000);
      put(1'b1, strap_id);
      for (int i = 0; i < 12; i++) put(1'b1, 4'hF);
      @(negedge clk);
      chk(!lad_oe && !mem_rd_en, "R1", "no cycle without start code", lad_oe, 0);
   endtask

   task automatic t_mismatch;
      int driven = 0;
      send_header(strap_id ^ 4'h1, 28'h0000010, 4'b0000);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (lad_oe) driven++;
      end
      chk(driven == 0, "R2", "id mismatch stays off bus", driven, 0);
   endtask

   task automatic t_abort;
      send_header(strap_id, 28'h0000040, 4'b0100);
      repeat (6) @(negedge clk);
      frame_n = 1'b0;
      lad_in  = 4'b0000;
      #1;
      chk(!lad_oe, "R11", "float in the abort clock", lad_oe, 0);
      @(negedge clk);
      frame_n = 1'b1;
      lad_in  = 4'hF;
      chk(!lad_oe, "R11", "float after abort", lad_oe, 0);
      repeat (4) @(negedge clk);
      chk(!lad_oe, "R11", "abandoned cycle stays off", lad_oe, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_start();
      read_chk(28'h123456A, 4'b0000, 1,   28'h123456A, "R3");
      read_chk(28'h0000081, 4'b0001, 2,   28'h0000080, "R4");
      read_chk(28'h0000207, 4'b0010, 4,   28'h0000204, "R4");
      read_chk(28'h00000A5, 4'b0100, 16,  28'h00000A0, "R6");
      read_chk(28'hABCDEF5, 4'b0111, 128, 28'hABCDE80, "R6");
      read_chk(28'h0000033, 4'b0011, 1,   28'h0000033, "R5");
      read_chk(28'h0000077, 4'b1111, 1,   28'h0000077, "R5");
      t_mismatch();
      read_chk(28'h0000011, 4'b0000, 1,   28'h0000011, "R2");
      t_abort();
      read_chk(28'h0000123, 4'b0001, 2,   28'h0000122, "R11");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule